// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Fence

This block sits beside a core's private cache and takes in coherence invalidate messages sent by other cores. It acknowledges each message in the same cycle it arrives. The acknowledge does not wait for the local cache line to be dropped. Instead, the line address goes into a small first-in first-out queue. The queue hands addresses to the cache one at a time, whenever the cache reports that it can take one.

Because acknowledgement runs ahead of invalidation, an ordinary load can still hit a line that another core has already overwritten, and so return the old local copy. Software that needs fresh data raises a load fence. Loads that follow the fence are held back until every invalidation that was queued when the fence arrived has reached the cache. The fence then reports completion with a single-cycle pulse, and the loads that follow read coherent data.

Top module: `inval_queue_fence`

## Requirements
- R1: While the queue holds fewer than DEPTH (default 8) entries, `inv_ack` is high in the same cycle as `inv_valid`, whatever the state of `cache_inv_ready`.
- R2: Accepted line addresses appear on `cache_inv_addr`, with `cache_inv_valid` high, in arrival order. Exactly one entry is removed on each clock edge where `cache_inv_valid` and `cache_inv_ready` are both high.
- R3: With no fence pending, `ld_go` equals `ld_req`, even when the address being loaded still has a queued invalidation. Such a load therefore returns the stale cached value.
- R4: While the queue holds DEPTH entries, `inv_ack` stays low, including in a cycle where an entry is being removed. A held message is accepted in the cycle after an entry is removed.
- R5: Once a fence request is taken, `ld_go` stays low until the last invalidation that was queued ahead of the fence has been removed. Loads after completion observe the coherent value.
- R6: `fence_done` is a one-cycle pulse in the cycle after the edge that removes the last entry queued ahead of the fence. `ld_go` follows `ld_req` from that cycle onward.
- R7: A fence requested while `cache_inv_valid` is low gives `fence_done` in the next cycle.
- R8: Invalidates accepted in the same cycle as the fence request, or later, do not delay that fence.
- R9: After reset the queue is empty, `cache_inv_valid` and `fence_done` are low, and loads are not blocked.
- R10: A `fence_req` raised while a fence is already pending is ignored, so only one `fence_done` pulse results.
- R11: A load requested in the same cycle as the fence request is treated as coming before the fence and is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Incoming invalidate message present |
| inv_addr | input | LINE_W | Line address to invalidate |
| inv_ack | output | 1 | Message accepted this cycle |
| cache_inv_valid | output | 1 | Queue head is offered to the cache |
| cache_inv_addr | output | LINE_W | Line address at the queue head |
| cache_inv_ready | input | 1 | Cache applies the offered invalidation this cycle |
| ld_req | input | 1 | Core wants to issue a load |
| ld_go | output | 1 | Load may proceed to the cache this cycle |
| fence_req | input | 1 | Load fence request, one cycle |
| fence_done | output | 1 | Fence complete, one-cycle pulse |

## Verification
A corrupted occupancy count shows at the ports in one of two ways. The acknowledge can drop too early or too late around the eighth entry, or `cache_inv_valid` can stay high on an empty queue; either appears within a cycle of the error. A wrong read pointer shows as an out-of-order address on the cache port the next time the head is offered. A fence counter that has drifted shows as a `fence_done` pulse that comes early, late or never, while `ld_go` is blocked for the wrong number of cycles. The bench also runs a stale-read scenario against a model of the cache, so that a fence which releases loads too early returns the old data instead of the new.

// File: rtl/inval_queue_fence.sv
module inval_queue_fence #(
  parameter int LINE_W = 6,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_addr,
  output logic              inv_ack,
  output logic              cache_inv_valid,
  output logic [LINE_W-1:0] cache_inv_addr,
  input  logic              cache_inv_ready,
  input  logic              ld_req,
  output logic              ld_go,
  input  logic              fence_req,
  output logic              fence_done
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LINE_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count, fence_left;
  logic              fence_pend;

  wire full = (count == CNT_W'(DEPTH));
  wire push = inv_valid && !full;
  wire pop  = (count != '0) && cache_inv_ready;

  assign inv_ack         = push;
  assign cache_inv_valid = (count != '0);
  assign cache_inv_addr  = slots[rd_ptr];
  assign fence_done      = fence_pend && (fence_left == '0);
  assign ld_go           = ld_req && (!fence_pend || fence_done);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) slots[wr_ptr] <= inv_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      fence_pend <= 1'b0;
      fence_left <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (fence_req && !fence_pend) begin
        fence_pend <= 1'b1;
        fence_left <= count - CNT_W'(pop);
      end else if (fence_pend) begin
        if (fence_left == '0) fence_pend <= 1'b0;
        else if (pop)         fence_left <= fence_left - 1'b1;
      end
    end
  end

  AST_ACK_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ack |=> cache_inv_valid);  // R2
  AST_HELD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ack |-> cache_inv_valid);  // R4
  AST_FENCE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && !fence_pend && cache_inv_valid && !cache_inv_ready |=> !ld_go);  // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |=> !fence_done);  // R6
  AST_EMPTY_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && !fence_pend && !cache_inv_valid |=> fence_done);  // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> !cache_inv_valid && !fence_done);  // R9
endmodule

// File: tb/tb_inval_queue_fence.sv
module tb_inval_queue_fence;
  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_valid = 0, cache_inv_ready = 0, ld_req = 0, fence_req = 0;
  logic [5:0] inv_addr = '0;
  logic inv_ack, cache_inv_valid, ld_go, fence_done;
  logic [5:0] cache_inv_addr;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  inval_queue_fence dut (.clk, .rst_n, .inv_valid, .inv_addr, .inv_ack,
    .cache_inv_valid, .cache_inv_addr, .cache_inv_ready, .ld_req, .ld_go,
    .fence_req, .fence_done);

  // cache stub: per-line valid and data, remote memory holds the coherent value
  logic       lv [64];
  logic [7:0] ld_data [64];
  logic [7:0] mem [64];
  always @(posedge clk)
    if (cache_inv_valid && cache_inv_ready) lv[cache_inv_addr] <= 1'b0;
  function automatic logic [7:0] load_val(input int a);
    return lv[a] ? ld_data[a] : mem[a];
  endfunction

  // {iv, ia[6], rdy, lr, fr, ack, cv, ca[6], go, done}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 6'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0,  1'b1, 1'b0},
    {1'b1, 6'd9,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd5,  1'b1, 1'b0},
    {1'b0, 6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'd5,  1'b1, 1'b0},
    {1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd9,  1'b0, 1'b0},
    {1'b1, 6'd12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd9,  1'b0, 1'b0},
    {1'b0, 6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'd9,  1'b0, 1'b0},
    {1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd12, 1'b1, 1'b1},
    {1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd12, 1'b1, 1'b0},
    {1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd12, 1'b0, 1'b0},
    {1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0},
    {1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0,  1'b1, 1'b1},
    {1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0,  1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [5:0] ia, input logic rdy,
                       input logic lr, input logic fr);
    @(negedge clk);
    inv_valid = iv; inv_addr = ia; cache_inv_ready = rdy; ld_req = lr; fence_req = fr;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin lv[i] = 1'b0; ld_data[i] = 8'h00; mem[i] = 8'h00; end
    drive(0, 0, 0, 1, 0); drive(0, 0, 0, 1, 0);
    chk("R9 cache_inv_valid", cache_inv_valid, 0);
    chk("R9 fence_done", fence_done, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      drive(v[19], v[18:13], v[12], v[11], v[10]);
      chk("R1 inv_ack", inv_ack, v[9]);
      chk("R2 cache_inv_valid", cache_inv_valid, v[8]);
      if (v[8]) chk("R2 cache_inv_addr", cache_inv_addr, v[7:2]);
      chk("R5/R8/R11 ld_go", ld_go, v[1]);
      chk("R6/R7 fence_done", fence_done, v[0]);
    end

    // R4 full queue and R2 ordering
    for (int i = 0; i < 8; i++) begin
      drive(1, 6'(20 + i), 0, 0, 0);
      chk("R1 ack below full", inv_ack, 1);
    end
    drive(1, 6'd40, 0, 0, 0);
    chk("R4 ack withheld when full", inv_ack, 0);
    drive(1, 6'd40, 1, 0, 0);
    chk("R4 ack withheld during pop", inv_ack, 0);
    chk("R2 head addr", cache_inv_addr, 20);
    drive(1, 6'd40, 0, 0, 0);
    chk("R4 ack after entry freed", inv_ack, 1);
    for (int i = 0; i < 8; i++) begin
      drive(0, 0, 1, 0, 0);
      chk("R2 order", cache_inv_addr, (i < 7) ? 21 + i : 40);
    end
    drive(0, 0, 0, 0, 0);
    chk("R2 drained", cache_inv_valid, 0);

    // R10 second fence ignored while pending
    drive(1, 6'd30, 0, 0, 0);
    drive(1, 6'd31, 0, 0, 0);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1);
    begin
      int pulses = 0;
      for (int i = 0; i < 6; i++) begin
        drive(0, 0, 1, 0, 0);
        if (fence_done) pulses++;
      end
      chk("R10 single fence_done", pulses, 1);
    end

    // R3 stale hit without fence, R5 coherent read after fence
    lv[7] = 1'b1; ld_data[7] = 8'hAA; mem[7] = 8'hBB;
    drive(1, 6'd7, 0, 0, 0);
    chk("R1 ack line 7", inv_ack, 1);
    drive(0, 0, 0, 1, 0);
    chk("R3 load not blocked", ld_go, 1);
    chk("R3 stale data", load_val(7), 8'hAA);
    drive(0, 0, 0, 1, 1);
    chk("R11 load with fence passes", ld_go, 1);
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 0, 1, 0);
      chk("R5 load stalled", ld_go, 0);
    end
    drive(0, 0, 1, 1, 0);
    chk("R5 stalled while applying", ld_go, 0);
    drive(0, 0, 0, 1, 0);
    chk("R6 fence_done", fence_done, 1);
    chk("R6 load released", ld_go, 1);
    chk("R5 coherent data", load_val(7), 8'hBB);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule